// File: doc/BRIEF.md
# Task Memory Window Remapper

This block sits between a guest processor and a 16MB RAM and keeps each guest task inside the part of RAM the hypervisor gave it. The RAM is split into 64KB blocks. The low 16 address bits select a byte inside a block and always reach RAM unchanged. For each of the upper eight bits, a mask register decides whether the guest drives it or whether a fixed-value register supplies it. A task therefore owns a power-of-two number of 64KB blocks, and it cannot form an address outside that set.

Only the hypervisor can change the two registers. A write counts only while the hypervisor-mode input is high, and guest writes are dropped. While the hypervisor runs, the remapping is bypassed so that it can reach all of RAM. A new setting applies to the first cycle after the write. The hypervisor can therefore change the window just before a one-cycle return to the guest.

Top module: `task_window_remap`

## Requirements
- R1: `ram_addr[15:0]` always equals `guest_addr[15:0]`, in every mode and for every setting.
- R2: While `hyp_mode` is low, each bit i of `ram_addr[23:16]` equals `guest_addr[16+i]` if bit i of the mask is 1, and bit i of the fixed value if the mask bit is 0.
- R3: While `hyp_mode` is high, `ram_addr` equals `guest_addr` bit for bit, whatever the register contents.
- R4: After a synchronous reset (`rst_n` low at a rising edge), the mask is all ones and the fixed value is zero, so guest addresses map to themselves.
- R5: On a rising edge with `cfg_wr` and `hyp_mode` both high, `cfg_wdata` is loaded into the mask when `cfg_sel` is 0, or into the fixed value when `cfg_sel` is 1. The new setting governs `ram_addr` from the cycle after that edge.
- R6: A rising edge with `cfg_wr` high and `hyp_mode` low changes neither register. The guest mapping seen on `ram_addr` stays the same afterwards.
- R7: In guest mode, every upper output bit that the mask leaves clear holds the fixed-value bit for any guest address. When the mask is zero, every guest address lands in the single 64KB block selected by the fixed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hyp_mode | input | 1 | High while the hypervisor is running |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 for the mask, 1 for the fixed value |
| cfg_wdata | input | 8 | Write data for the selected register |
| guest_addr | input | 24 | Physical address issued by the processor |
| ram_addr | output | 24 | Remapped address sent to RAM |

## Verification
The assertions assume that `hyp_mode`, `cfg_wr`, `cfg_sel` and `cfg_wdata` are stable across each rising edge, and that `guest_addr` holds steady long enough for the combinational output to be sampled. The stimulus changes every input only on the falling edge, and it reads results one time unit after that change. A register write is held for exactly one rising edge, and the strobe is released on the next falling edge. The guest-write case raises the strobe with `hyp_mode` low, so the write-ignore property is exercised, not just left idle.

// File: rtl/tmw_pkg.sv
// Package: shared types of the task memory window remapper.
// Assumes: a single-bit write selector picks one of two config registers.
package tmw_pkg;
    typedef enum logic {
        CFG_MASK  = 1'b0,
        CFG_FIXED = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/tmw_cfg_regs.sv
// Module: tmw_cfg_regs
// Holds the upper-bit mask and the fixed-value register of the window.
// Assumes: writes are qualified by hypervisor mode; reset is synchronous
// and active low; outputs change only on the rising clock edge.
module tmw_cfg_regs
    import tmw_pkg::*;
#(
    parameter int UPPER_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hyp_mode,
    input  logic               wr_en,
    input  cfg_sel_e           wr_sel,
    input  logic [UPPER_W-1:0] wr_data,
    output logic [UPPER_W-1:0] mask_q,
    output logic [UPPER_W-1:0] fixed_q
);
    logic wr_ok;

    // Purpose: accept a write only when the hypervisor issues it.
    always_comb wr_ok = wr_en && hyp_mode;

    // Purpose: reset to identity mapping, then load the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            fixed_q <= '0;
        end else if (wr_ok) begin
            if (wr_sel == CFG_MASK) mask_q  <= wr_data;
            else                    fixed_q <= wr_data;
        end
    end

    assert_reset_identity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_q == '1 && fixed_q == '0));

    assert_guest_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hyp_mode) |=> ($stable(mask_q) && $stable(fixed_q)));

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hyp_mode && wr_sel == CFG_MASK) |=> (mask_q == $past(wr_data)));

    assert_fixed_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hyp_mode && wr_sel == CFG_FIXED) |=> (fixed_q == $past(wr_data)));
endmodule

// File: rtl/tmw_bit_select.sv
// Module: tmw_bit_select
// One upper address line: passes the guest bit, or substitutes the fixed bit.
// Assumes: bypass has priority over the mask (hypervisor sees all RAM).
module tmw_bit_select (
    input  logic guest_bit,
    input  logic mask_bit,
    input  logic fixed_bit,
    input  logic bypass,
    output logic out_bit
);
    // Purpose: choose the source of this address line.
    always_comb begin
        if (bypass || mask_bit) out_bit = guest_bit;
        else                    out_bit = fixed_bit;
    end
endmodule

// File: rtl/tmw_window_mux.sv
// Module: tmw_window_mux
// Builds the RAM address: block offset passes through, upper lines go
// through one tmw_bit_select cell each.
// Assumes: ADDR_W > BLK_W; purely combinational.
module tmw_window_mux #(
    parameter int ADDR_W = 24,
    parameter int BLK_W  = 16
) (
    input  logic [ADDR_W-1:0]       guest_addr,
    input  logic [ADDR_W-BLK_W-1:0] mask,
    input  logic [ADDR_W-BLK_W-1:0] fixed_val,
    input  logic                    bypass,
    output logic [ADDR_W-1:0]       ram_addr
);
    localparam int UPPER_W = ADDR_W - BLK_W;

    logic [UPPER_W-1:0] upper;

    // Purpose: the in-block offset is never remapped.
    assign ram_addr[BLK_W-1:0] = guest_addr[BLK_W-1:0];

    for (genvar i = 0; i < UPPER_W; i++) begin : g_line
        tmw_bit_select u_sel (
            .guest_bit (guest_addr[BLK_W+i]),
            .mask_bit  (mask[i]),
            .fixed_bit (fixed_val[i]),
            .bypass    (bypass),
            .out_bit   (upper[i])
        );
    end

    // Purpose: join the remapped block number onto the offset.
    assign ram_addr[ADDR_W-1:BLK_W] = upper;
endmodule

// File: rtl/task_window_remap.sv
// Module: task_window_remap (top)
// Confines a guest task to a power-of-two set of 64KB blocks of RAM.
// Assumes: hyp_mode high means the hypervisor owns the bus; config
// writes are single-cycle strobes sampled on the rising edge.
module task_window_remap
    import tmw_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BLK_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hyp_mode,
    input  logic                    cfg_wr,
    input  logic                    cfg_sel,
    input  logic [ADDR_W-BLK_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0]       guest_addr,
    output logic [ADDR_W-1:0]       ram_addr
);
    localparam int UPPER_W = ADDR_W - BLK_W;

    logic [UPPER_W-1:0] mask_q;
    logic [UPPER_W-1:0] fixed_q;
    cfg_sel_e           sel_e;

    // Purpose: give the raw select pin its typed meaning.
    always_comb sel_e = cfg_sel_e'(cfg_sel);

    tmw_cfg_regs #(.UPPER_W(UPPER_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hyp_mode (hyp_mode),
        .wr_en    (cfg_wr),
        .wr_sel   (sel_e),
        .wr_data  (cfg_wdata),
        .mask_q   (mask_q),
        .fixed_q  (fixed_q)
    );

    tmw_window_mux #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_mux (
        .guest_addr (guest_addr),
        .mask       (mask_q),
        .fixed_val  (fixed_q),
        .bypass     (hyp_mode),
        .ram_addr   (ram_addr)
    );

    assert_offset_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_addr[BLK_W-1:0] == guest_addr[BLK_W-1:0]);

    assert_hyp_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hyp_mode |-> (ram_addr == guest_addr));

    assert_confined_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hyp_mode |-> (((ram_addr[ADDR_W-1:BLK_W] ^ fixed_q) & ~mask_q) == '0));
endmodule

// File: tb/task_window_remap_tb.sv
// Bench: scoreboard. The driver pushes expected RAM addresses into a
// queue; the monitor pops each item and compares it with the output.
module task_window_remap_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 24;
    localparam int BLK_W  = 16;
    localparam int UPPER_W = ADDR_W - BLK_W;

    typedef struct {
        logic [ADDR_W-1:0] exp;
        string             req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hyp_mode = 1'b0;
    logic cfg_wr = 1'b0;
    logic cfg_sel = 1'b0;
    logic [UPPER_W-1:0] cfg_wdata = '0;
    logic [ADDR_W-1:0] guest_addr = '0;
    logic [ADDR_W-1:0] ram_addr;

    item_t sb_q[$];
    event  item_ev;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    logic [UPPER_W-1:0] m_mask = '1;
    logic [UPPER_W-1:0] m_fixed = '0;

    task_window_remap #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .hyp_mode(hyp_mode), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .guest_addr(guest_addr),
        .ram_addr(ram_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [ADDR_W-1:0] model(input logic [ADDR_W-1:0] g, input logic hyp);
        logic [ADDR_W-1:0] r;
        r = g;
        if (!hyp) r[ADDR_W-1:BLK_W] = (g[ADDR_W-1:BLK_W] & m_mask) | (m_fixed & ~m_mask);
        return r;
    endfunction

    // Driver: apply one address and queue its expected result.
    task automatic drive(input logic [ADDR_W-1:0] g, input logic hyp, input string req);
        item_t it;
        @(negedge clk);
        guest_addr = g;
        hyp_mode = hyp;
        it.exp = model(g, hyp);
        it.req = req;
        sb_q.push_back(it);
        ->item_ev;
    endtask

    // Config write held for one rising edge; hyp selects legality.
    task automatic cfg_write(input logic sel, input logic [UPPER_W-1:0] d, input logic hyp);
        @(negedge clk);
        hyp_mode = hyp;
        cfg_wr = 1'b1;
        cfg_sel = sel;
        cfg_wdata = d;
        @(posedge clk);
        if (hyp) begin
            if (sel) m_fixed = d;
            else     m_mask = d;
        end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Monitor: compare output with the head of the scoreboard.
    initial begin
        forever begin
            @(item_ev);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_vec++;
                if (ram_addr !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: ram_addr=%06h expected %06h", it.req, ram_addr, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R4: identity after reset
        drive(24'h000000, 1'b0, "R4");
        drive(24'hFFFFFF, 1'b0, "R4");
        drive(24'h5A1234, 1'b0, "R4");
        // R6: guest writes to both registers are dropped
        cfg_write(1'b0, 8'h00, 1'b0);
        cfg_write(1'b1, 8'hC3, 1'b0);
        drive(24'h9ABCDE, 1'b0, "R6");
        // R5: window of 16 blocks, visible in first guest cycle after write
        cfg_write(1'b1, 8'h35, 1'b1);
        cfg_write(1'b0, 8'hF0, 1'b1);
        drive(24'hABCDEF, 1'b0, "R5");
        drive(24'h0F0001, 1'b0, "R2");
        drive(24'hF0FFFF, 1'b0, "R2");
        // R3: hypervisor bypass with a narrow window loaded
        drive(24'h123456, 1'b1, "R3");
        drive(24'hFFFFFF, 1'b1, "R3");
        // R7: single block window
        cfg_write(1'b0, 8'h00, 1'b1);
        cfg_write(1'b1, 8'hA3, 1'b1);
        drive(24'h000000, 1'b0, "R7");
        drive(24'hFFFFFF, 1'b0, "R7");
        drive(24'h5C7E11, 1'b0, "R7");
        // R1: offset bits through a scattered mask
        cfg_write(1'b0, 8'h81, 1'b1);
        drive(24'h7E8001, 1'b0, "R1");
        drive(24'hFF0000, 1'b0, "R1");
        // R6: guest write after configuration leaves mapping intact
        cfg_write(1'b0, 8'hFF, 1'b0);
        drive(24'h42BEEF, 1'b0, "R6");
        // R4: reset again restores identity
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        m_mask = '1;
        m_fixed = '0;
        @(negedge clk) rst_n = 1'b1;
        drive(24'hC0FFEE, 1'b0, "R4");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule